// File: doc/BRIEF.md
# Dual-Compare Timer Output Channel

This block is the output-compare half of a timer channel. Each cycle it chooses one time base from three sources: a shared counter bus, a second shared counter bus, or a local counter behind a programmable divider. It compares that time base with two working compare values. A match on one compare value drives the output pin to one level, and a match on the other drives it to the opposite level. A polarity bit decides which compare value sets the output and which clears it.

Software writes the compare values into holding registers. The holding values move into the working stage only while the selected time base reads zero, so a new period can be set up without disturbing the current one. A control write can also force a match on either compare value. Every match event sets a sticky flag, which is routed to an interrupt line or to a trigger line. A debug freeze input stops the channel when the channel has freezing enabled.

Top module: `dcmp_out_chan`

## Requirements
- R1: The time-base select field, control bits 4:3, picks bus A for code 00, the secondary bus for code 01, and the local counter for code 11. The reserved code 10 behaves like 11.
- R2: The local counter changes only while the run bit (control bit 5) is 1. While running, it steps by one every (divide value + 1) clock cycles. The divide value sits in control bits 10:9. Counting starts from 0 after reset.
- R3: A write to address 1 loads the A holding register, and a write to address 2 loads the B holding register. A holding value moves to its working register at a clock edge where the selected time base is zero. Compares always use the working values. Both holding and working registers reset to all ones.
- R4: With polarity (control bit 0) at 1, an A match drives the output high and a B match drives it low. With polarity at 0 the two roles swap. The output changes at the clock edge that ends the cycle in which the time base equals the working value. At all other times it holds.
- R5: When A and B events occur in the same cycle, the output takes the level that B gives.
- R6: A control write (address 0) with bit 7 set acts as an A match at that write's edge. With bit 8 set it acts as a B match. The bits are not stored, so they act only once.
- R7: Every A or B event sets a sticky flag. Writing 1 to bit 0 at address 3 clears the flag, but a match in the same cycle wins over the clear.
- R8: With the flag-enable bit (control bit 1) at 1, the flag appears on irq_o when the route bit (control bit 2) is 0 and on trig_o when it is 1. With flag-enable at 0 both lines stay low.
- R9: While freeze enable (control bit 6) and frz_i are both 1, the output, flag, local counter and all registers hold, and all writes are ignored.
- R10: After reset the output, the flag, irq_o and trig_o are 0, and all control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 A, 2 B, 3 flag clear |
| wr_data | input | 16 | Write data |
| bus_a_i | input | 16 | Shared counter bus A |
| bus_sec_i | input | 16 | Secondary shared counter bus |
| frz_i | input | 1 | Debug freeze request |
| out_o | output | 1 | Channel output flip-flop |
| irq_o | output | 1 | Flag routed as interrupt request |
| trig_o | output | 1 | Flag routed as trigger |

## Verification
The hardest case to reach from the ports is an A and a B event landing in the same cycle. The bench reaches it by loading equal working values through a zero on the time base. It first forces the output to the level opposite B's, then presents the shared value, so that only the B priority rule can explain the result. It runs this under both polarities. Rate checks on the local counter sample at cycle counts derived from the divide value, just before and just after the expected match edge.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_A    = 2'd1,
      REG_B    = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      TB_BUS_A  = 2'd0,
      TB_BUS_SEC = 2'd1,
      TB_RSVD   = 2'd2,
      TB_LOCAL  = 2'd3
   } tb_sel_e;

   localparam int POL_BIT   = 0;
   localparam int FEN_BIT   = 1;
   localparam int ROUTE_BIT = 2;
   localparam int SEL_LSB   = 3;
   localparam int RUN_BIT   = 5;
   localparam int FRZ_BIT   = 6;
   localparam int FA_BIT    = 7;
   localparam int FB_BIT    = 8;
   localparam int DIV_LSB   = 9;
endpackage

// File: rtl/dcmp_local_ctr.sv
module dcmp_local_ctr #(
   parameter int CW    = 16,
   parameter int PRE_W = 2,
   localparam int PW   = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] div_val,
   output logic [CW-1:0] cnt_o
);
   logic tick;

   generate
      if (PRE_W == 0) begin : g_nodiv
         logic unused_div;
         assign unused_div = ^div_val;
         assign tick = run;
      end else begin : g_div
         logic [PW-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q <= '0;
            end else if (run) begin
               if (pc_q >= div_val) pc_q <= '0;
               else                 pc_q <= pc_q + 1'b1;
            end
         end
         assign tick = run && (pc_q >= div_val);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_o <= '0;
      else if (tick) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/dcmp_tb_mux.sv
module dcmp_tb_mux #(
   parameter int CW            = 16,
   parameter bit RSVD_AS_LOCAL = 1'b1
) (
   input  logic [1:0]    sel,
   input  logic [CW-1:0] bus_a,
   input  logic [CW-1:0] bus_sec,
   input  logic [CW-1:0] local_cnt,
   output logic [CW-1:0] tb
);
   import dcmp_pkg::*;

   logic [CW-1:0] rsvd_src;

   generate
      if (RSVD_AS_LOCAL) begin : g_rsvd_local
         assign rsvd_src = local_cnt;
      end else begin : g_rsvd_zero
         assign rsvd_src = '0;
      end
   endgenerate

   always_comb begin
      unique case (tb_sel_e'(sel))
         TB_BUS_A:   tb = bus_a;
         TB_BUS_SEC: tb = bus_sec;
         TB_RSVD:    tb = rsvd_src;
         default:    tb = local_cnt;
      endcase
   end
endmodule

// File: rtl/dcmp_cmp_pair.sv
module dcmp_cmp_pair #(
   parameter int CW    = 16,
   parameter int SLOTS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [SLOTS-1:0] wr_sel,
   input  logic [CW-1:0]    wr_val,
   input  logic [CW-1:0]    tb,
   output logic [SLOTS-1:0] match
);
   localparam logic [CW-1:0] ZERO = '0;

   logic reload;
   assign reload = !hold && (tb == ZERO);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [CW-1:0] hold_q;
      logic [CW-1:0] work_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '1;
            work_q <= '1;
         end else if (!hold) begin
            if (wr_sel[i]) hold_q <= wr_val;
            if (reload)    work_q <= hold_q;
         end
      end

      assign match[i] = (tb == work_q);
   end
endmodule

// File: rtl/dcmp_out_chan.sv
module dcmp_out_chan #(
   parameter int CW            = 16,
   parameter int PRE_W         = 2,
   parameter bit RSVD_AS_LOCAL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic [CW-1:0] bus_a_i,
   input  logic [CW-1:0] bus_sec_i,
   input  logic          frz_i,
   output logic          out_o,
   output logic          irq_o,
   output logic          trig_o
);
   import dcmp_pkg::*;

   localparam int PW        = (PRE_W > 0) ? PRE_W : 1;
   localparam int FIELD_END = DIV_LSB + PW;

   generate
      if (CW < FIELD_END) begin : g_bad_width
         $error("dcmp_out_chan: CW too narrow for control fields");
      end
   endgenerate

   logic          pol_q, fen_q, dst_q, pren_q, frzen_q;
   logic [1:0]    bsel_q;
   logic [PW-1:0] div_q;
   logic          flag_q;

   logic          frozen;
   logic          ctrl_wr, stat_clr;
   logic [1:0]    slot_wr;
   logic [1:0]    match;
   logic          evt_a, evt_b;
   logic [CW-1:0] local_cnt, tb;

   assign frozen   = frzen_q && frz_i;
   assign ctrl_wr  = wr_en && !frozen && (reg_sel_e'(wr_addr) == REG_CTRL);
   assign stat_clr = wr_en && !frozen && (reg_sel_e'(wr_addr) == REG_STAT) && wr_data[0];
   assign slot_wr[0] = wr_en && !frozen && (reg_sel_e'(wr_addr) == REG_A);
   assign slot_wr[1] = wr_en && !frozen && (reg_sel_e'(wr_addr) == REG_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= 1'b0;
         fen_q   <= 1'b0;
         dst_q   <= 1'b0;
         bsel_q  <= 2'b00;
         pren_q  <= 1'b0;
         frzen_q <= 1'b0;
         div_q   <= '0;
      end else if (ctrl_wr) begin
         pol_q   <= wr_data[POL_BIT];
         fen_q   <= wr_data[FEN_BIT];
         dst_q   <= wr_data[ROUTE_BIT];
         bsel_q  <= wr_data[SEL_LSB +: 2];
         pren_q  <= wr_data[RUN_BIT];
         frzen_q <= wr_data[FRZ_BIT];
         div_q   <= wr_data[DIV_LSB +: PW];
      end
   end

   dcmp_local_ctr #(.CW(CW), .PRE_W(PRE_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (pren_q && !frozen),
      .div_val (div_q),
      .cnt_o   (local_cnt)
   );

   dcmp_tb_mux #(.CW(CW), .RSVD_AS_LOCAL(RSVD_AS_LOCAL)) u_mux (
      .sel       (bsel_q),
      .bus_a     (bus_a_i),
      .bus_sec   (bus_sec_i),
      .local_cnt (local_cnt),
      .tb        (tb)
   );

   dcmp_cmp_pair #(.CW(CW), .SLOTS(2)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (frozen),
      .wr_sel (slot_wr),
      .wr_val (wr_data),
      .tb     (tb),
      .match  (match)
   );

   assign evt_a = !frozen && (match[0] || (ctrl_wr && wr_data[FA_BIT]));
   assign evt_b = !frozen && (match[1] || (ctrl_wr && wr_data[FB_BIT]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_o <= 1'b0;
      else if (evt_b) out_o <= !pol_q;
      else if (evt_a) out_o <= pol_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (evt_a || evt_b) flag_q <= 1'b1;
      else if (stat_clr)       flag_q <= 1'b0;
   end

   assign irq_o  = flag_q && fen_q && !dst_q;
   assign trig_o = flag_q && fen_q && dst_q;
endmodule

// File: rtl/dcmp_out_chan_chk.sv
module dcmp_out_chan_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frozen,
   input logic          pol_q,
   input logic          fen_q,
   input logic          dst_q,
   input logic          pren_q,
   input logic          evt_a,
   input logic          evt_b,
   input logic          stat_clr,
   input logic          flag_q,
   input logic [CW-1:0] local_cnt,
   input logic          out_o,
   input logic          irq_o,
   input logic          trig_o
);
   // R9
   frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> ($stable(out_o) && $stable(flag_q) && $stable(local_cnt)));

   // R5
   b_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_b |=> (out_o == !$past(pol_q)));

   // R4
   a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_a && !evt_b) |=> (out_o == $past(pol_q)));

   // R4
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_a && !evt_b) |=> $stable(out_o));

   // R7
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !evt_a && !evt_b) |=> !flag_q);

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !stat_clr) |=> flag_q);

   // R8
   route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_o, trig_o}));

   // R8
   route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o || trig_o) |-> (fen_q && (irq_o != dst_q)));

   // R2
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pren_q |=> $stable(local_cnt));
endmodule

bind dcmp_out_chan dcmp_out_chan_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frozen    (frozen),
   .pol_q     (pol_q),
   .fen_q     (fen_q),
   .dst_q     (dst_q),
   .pren_q    (pren_q),
   .evt_a     (evt_a),
   .evt_b     (evt_b),
   .stat_clr  (stat_clr),
   .flag_q    (flag_q),
   .local_cnt (local_cnt),
   .out_o     (out_o),
   .irq_o     (irq_o),
   .trig_o    (trig_o)
);

// File: tb/dcmp_out_chan_test.sv
`timescale 1ns/1ps
module dcmp_out_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] bus_a = 16'd0;
   logic [15:0] bus_sec = 16'd0;
   logic        frz = 1'b0;
   logic        out_o, irq_o, trig_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dcmp_out_chan uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .bus_a_i(bus_a), .bus_sec_i(bus_sec),
      .frz_i(frz), .out_o(out_o), .irq_o(irq_o), .trig_o(trig_o)
   );

   // {bus A value, expected output} with A=100, B=200, polarity 1
   localparam logic [16:0] VEC [7] = '{
      {16'd5,   1'b0}, {16'd100, 1'b1}, {16'd150, 1'b1}, {16'd200, 1'b0},
      {16'd250, 1'b0}, {16'd100, 1'b1}, {16'd200, 1'b0}
   };

   function automatic logic [15:0] cw(input bit pol, input bit fen, input bit dst,
                                      input bit [1:0] sel, input bit run, input bit fz,
                                      input bit fa, input bit fb, input bit [1:0] dv);
      return {5'd0, dv, fb, fa, fz, run, sel, dst, fen, pol};
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic step(input logic [15:0] a, input logic [15:0] s);
      @(negedge clk);
      bus_a = a; bus_sec = s;
      @(posedge clk); #1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_cyc(3);
      #1 rst_n = 1'b1;
      wait_cyc(1);
      // R10 reset state
      chk(out_o, 0, "R10 out");
      chk(irq_o, 0, "R10 irq");
      chk(trig_o, 0, "R10 trig");

      // R4 table walk on bus A
      wr(2'd0, cw(1,1,0,2'b00,0,0,0,0,0));
      wr(2'd1, 16'd100);
      wr(2'd2, 16'd200);
      step(0, 0); step(0, 0);
      for (int i = 0; i < 7; i++) begin
         step(VEC[i][16:1], 0);
         chk(out_o, VEC[i][0], "R4 table");
      end
      chk(irq_o, 1, "R8 irq route");
      chk(trig_o, 0, "R8 trig idle");

      // R7 clear and sticky
      step(5, 0);
      wr(2'd3, 16'd1);
      chk(irq_o, 0, "R7 clear");
      step(5, 0);
      chk(irq_o, 0, "R7 stays clear");
      step(100, 0);
      chk(out_o, 1, "R4 set");
      step(5, 0);
      chk(irq_o, 1, "R7 sticky");

      // R8 routing and enable
      wr(2'd0, cw(1,1,1,2'b00,0,0,0,0,0));
      chk(trig_o, 1, "R8 trig route");
      chk(irq_o, 0, "R8 irq off");
      wr(2'd0, cw(1,0,1,2'b00,0,0,0,0,0));
      chk({15'd0, trig_o | irq_o}, 0, "R8 disabled");

      // R4 polarity 0
      wr(2'd0, cw(0,1,0,2'b00,0,0,0,0,0));
      chk(out_o, 1, "R4 pol change holds");
      step(100, 0);
      chk(out_o, 0, "R4 pol0 A clears");
      step(200, 0);
      chk(out_o, 1, "R4 pol0 B sets");

      // R3 double buffering
      step(50, 0);
      wr(2'd1, 16'd500);
      step(500, 0);
      chk(out_o, 1, "R3 held value not used");
      step(100, 0);
      chk(out_o, 0, "R3 old A active");
      step(0, 0);
      step(200, 0);
      chk(out_o, 1, "R3 B after reload");
      step(500, 0);
      chk(out_o, 0, "R3 new A active");

      // R5 simultaneous match, both polarities
      step(50, 0);
      wr(2'd0, cw(1,1,0,2'b00,0,0,0,0,0));
      wr(2'd1, 16'd300);
      wr(2'd2, 16'd300);
      step(0, 0); step(0, 0);
      wr(2'd0, cw(1,1,0,2'b00,0,0,1,0,0));
      chk(out_o, 1, "R6 force A");
      step(0, 0);
      chk(out_o, 1, "R6 force A holds");
      step(300, 0);
      chk(out_o, 0, "R5 B wins pol1");
      step(50, 0);
      wr(2'd0, cw(0,1,0,2'b00,0,0,0,0,0));
      wr(2'd0, cw(0,1,0,2'b00,0,0,1,0,0));
      chk(out_o, 0, "R6 force A pol0");
      step(300, 0);
      chk(out_o, 1, "R5 B wins pol0");

      // R6 force B and one-shot behaviour
      step(50, 0);
      wr(2'd0, cw(1,1,0,2'b00,0,0,0,0,0));
      chk(out_o, 1, "R6 no force no change");
      wr(2'd0, cw(1,1,0,2'b00,0,0,0,1,0));
      chk(out_o, 0, "R6 force B");
      wr(2'd0, cw(1,1,0,2'b00,0,0,1,0,0));
      chk(out_o, 1, "R6 force A after B");
      step(50, 0); step(50, 0);
      chk(out_o, 1, "R6 force not lingering");

      // R1 secondary bus
      wr(2'd0, cw(1,1,0,2'b01,0,0,0,0,0));
      wr(2'd1, 16'd1000);
      wr(2'd2, 16'd2000);
      step(50, 0);
      step(1000, 5);
      chk(out_o, 1, "R1 bus A ignored");
      step(1000, 2000);
      chk(out_o, 0, "R1 sec B match");
      step(1000, 5);
      chk(out_o, 0, "R1 sec hold");
      step(50, 1000);
      chk(out_o, 1, "R1 sec A match");

      // R2 local counter, reserved code
      wr(2'd0, cw(1,1,0,2'b11,0,0,0,0,1));
      wr(2'd1, 16'd6);
      wr(2'd2, 16'd9);
      wr(2'd0, cw(1,1,0,2'b11,0,0,0,1,1));
      chk(out_o, 0, "R6 force B local");
      wr(2'd0, cw(1,1,0,2'b10,1,0,0,0,1));
      wait_cyc(10);
      chk(out_o, 0, "R2 before A count");
      wait_cyc(4);
      chk(out_o, 1, "R1 R2 local A match");
      wait_cyc(6);
      chk(out_o, 0, "R2 local B match");

      // R9 freeze
      wr(2'd0, cw(1,1,0,2'b00,0,1,0,0,0));
      step(0, 0);
      chk(irq_o, 1, "R9 flag before freeze");
      @(negedge clk) frz = 1'b1;
      step(6, 0);
      chk(out_o, 0, "R9 output held");
      wr(2'd3, 16'd1);
      chk(irq_o, 1, "R9 clear ignored");
      @(negedge clk) frz = 1'b0;
      @(posedge clk); #1;
      chk(out_o, 1, "R9 resumes");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule